// File: doc/BRIEF.md
# Dual-Output Fused Product Sum and Difference Unit

This block takes four binary32 operands x, y, z and w and returns two results in the same cycle: the sum x*y + z*w and the difference x*y - z*w. Both products are formed exactly and aligned once. The block adds and subtracts the aligned products in parallel. Each of the two outputs is then normalized and rounded once, toward negative infinity, with its own guard and sticky information. No product is rounded before it is combined.

The datapath has six register stages and one valid bit that travels with the data. It has no stall and accepts a new operand set on every cycle. The stages are named as follows:

- MUL: unpack the operands, detect special values and form the exact products.
- ALIGN: shift the product with the smaller exponent to the right and fold the lost bits into a sticky bit.
- ADDSUB: form the signed sum and the signed difference.
- LEAD: take the absolute value and find the leading one.
- ROUND: normalize, round toward negative infinity and pack the result.
- OUT: replace the packed result with NaN or infinity where a special case applies.

Top module: `fpdual_fma`

## Requirements
- R1: `out_sum` is x*y + z*w, computed from the exact products and rounded once toward negative infinity. For example, (1+2^-23)·(-(1+2^-23)) + 1·1 gives 0xB4800001.
- R2: `out_diff` is x*y - z*w, computed from the exact products and rounded once toward negative infinity on its own.
- R3: If `in_valid` is high at a rising edge, `out_valid` is high exactly six rising edges later. At that point `out_sum` and `out_diff` hold both results of that operand set. The unit accepts a new operand set on every cycle.
- R4: A sum or difference that is exactly zero is returned as negative zero, 0x80000000.
- R5: A NaN on any input, or an infinity multiplied by a zero in either product, makes both outputs the quiet NaN 0x7FC00000.
- R6: Infinite products affect each output separately. If an output combines two infinities of opposite effective sign, that output alone is 0x7FC00000. Otherwise an output that involves an infinity is the signed infinity (exponent field 0xFF, fraction 0).
- R7: An input with exponent field 0 is treated as a zero of its sign, whatever its fraction bits hold.
- R8: A finite result whose magnitude is too large saturates. A positive result becomes 0x7F7FFFFF and a negative result becomes 0xFF800000. A finite computation never yields +infinity (0x7F800000).
- R9: A nonzero finite result whose biased exponent would fall below 1 is flushed to a zero of its own sign: 0x00000000 if positive, 0x80000000 if negative.
- R10: If the z operand has exponent field 0, `out_sum` and `out_diff` are equal.
- R11: While `rst_n` is low, `out_valid`, `out_sum` and `out_diff` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operand set on the inputs is valid |
| in_x | input | 32 | Operand x, binary32 |
| in_y | input | 32 | Operand y, binary32 |
| in_z | input | 32 | Operand z, binary32 |
| in_w | input | 32 | Operand w, binary32 |
| out_valid | output | 1 | Results are valid, six cycles after the input |
| out_sum | output | 32 | x*y + z*w, rounded toward negative infinity |
| out_diff | output | 32 | x*y - z*w, rounded toward negative infinity |

## Verification
The assertions check the following on every cycle:

- The six-cycle valid latency.
- That a product of two normal operands has its leading one in the top two bits.
- That an exact zero at LEAD becomes negative zero at ROUND.
- That a finite result never reaches +infinity.
- That a zero z produces equal outputs.

The exact rounded values can only be shown by the bench scenarios. These cover the floor direction on positive and negative values, cancellation that proves fused rounding, and sticky bits from wide alignment gaps. They also cover the NaN and infinity cases per output, saturation, flush of tiny results and subnormal inputs.

// File: rtl/fpdual_pkg.sv
package fpdual_pkg;
    localparam int EXP_W    = 8;
    localparam int SIG_W    = 24;
    localparam int WORD_W   = 1 + EXP_W + SIG_W - 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int GUARD    = 4;
    localparam int FIELD_W  = PROD_W + GUARD;
    localparam int ACC_W    = FIELD_W + 2;
    localparam int EXPS_W   = EXP_W + 2;
    localparam int N_STAGES = 6;

    typedef struct packed {
        logic              sign;
        logic              nan;
        logic              inf;
        logic [EXPS_W-1:0] exp;
        logic [PROD_W-1:0] sig;
    } prod_t;

    typedef struct packed {
        logic nan;
        logic inf;
        logic sign;
    } spec_t;
endpackage

// File: rtl/fpdual_mul.sv
module fpdual_mul
    import fpdual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output prod_t             prod
);
    logic [EXP_W-1:0] ea, eb;
    logic             a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [SIG_W-1:0] ma, mb;
    prod_t            nxt;

    always_comb begin
        ea     = opa[WORD_W-2 -: EXP_W];
        eb     = opb[WORD_W-2 -: EXP_W];
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        a_inf  = (ea == EXP_W'(EXP_MAX)) && (opa[SIG_W-2:0] == '0);
        b_inf  = (eb == EXP_W'(EXP_MAX)) && (opb[SIG_W-2:0] == '0);
        a_nan  = (ea == EXP_W'(EXP_MAX)) && (opa[SIG_W-2:0] != '0);
        b_nan  = (eb == EXP_W'(EXP_MAX)) && (opb[SIG_W-2:0] != '0);
        ma     = {1'b1, opa[SIG_W-2:0]};
        mb     = {1'b1, opb[SIG_W-2:0]};
        nxt.sign = opa[WORD_W-1] ^ opb[WORD_W-1];
        nxt.nan  = a_nan | b_nan | (a_inf & b_zero) | (b_inf & a_zero);
        nxt.inf  = (a_inf | b_inf) & ~nxt.nan;
        if (a_zero || b_zero || a_inf || b_inf || a_nan || b_nan) begin
            nxt.exp = '0;
            nxt.sig = '0;
        end else begin
            nxt.exp = {2'b00, ea} + {2'b00, eb};
            nxt.sig = ma * mb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prod <= '0;
        else        prod <= nxt;
    end

    // R1: a product of two normal operands keeps its leading one in the top two bits
    assert_product_normalized_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (opa[WORD_W-2 -: EXP_W] inside {[1:EXP_MAX-1]} && opb[WORD_W-2 -: EXP_W] inside {[1:EXP_MAX-1]})
        |=> (prod.sig[PROD_W-1 -: 2] != 2'b00));
endmodule

// File: rtl/fpdual_round.sv
module fpdual_round
    import fpdual_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc,
    input  logic [EXPS_W-1:0]       emax,
    input  spec_t                   spec,
    output logic [WORD_W-1:0]       res
);
    localparam int MAG_W   = ACC_W - 1;
    localparam int POS_W   = $clog2(MAG_W);
    localparam int RES_EW  = EXPS_W + 2;
    localparam int EXP_OFF = BIAS + 2 * (SIG_W - 1) + GUARD;

    // LEAD stage
    logic             neg_d;
    logic [MAG_W-1:0] mag_d;
    logic [POS_W-1:0] lp_d;
    logic             neg_q, zero_q;
    logic [MAG_W-1:0] mag_q;
    logic [POS_W-1:0] lp_q;
    logic [EXPS_W-1:0] emax_q;
    spec_t            spec4_q, spec5_q;

    always_comb begin
        neg_d = acc[ACC_W-1];
        mag_d = neg_d ? MAG_W'(-acc) : MAG_W'(acc);
        lp_d  = '0;
        for (int i = 0; i < MAG_W; i++)
            if (mag_d[i]) lp_d = POS_W'(i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q   <= 1'b0;
            zero_q  <= 1'b0;
            mag_q   <= '0;
            lp_q    <= '0;
            emax_q  <= '0;
            spec4_q <= '0;
        end else begin
            neg_q   <= neg_d;
            zero_q  <= (mag_d == '0);
            mag_q   <= mag_d;
            lp_q    <= lp_d;
            emax_q  <= emax;
            spec4_q <= spec;
        end
    end

    // ROUND stage
    logic [MAG_W-1:0]  norm;
    logic [SIG_W-1:0]  mant;
    logic              rest;
    logic [SIG_W:0]    mant_r;
    logic [RES_EW-1:0] exp_s;
    logic              unused_hidden;
    logic [WORD_W-1:0] fin_d, fin_q;

    always_comb begin
        norm   = mag_q << (POS_W'(MAG_W - 1) - lp_q);
        mant   = norm[MAG_W-1 -: SIG_W];
        rest   = |norm[MAG_W-SIG_W-1:0];
        mant_r = {1'b0, mant} + (SIG_W+1)'(neg_q & rest);
        exp_s  = {2'b00, emax_q} + RES_EW'(lp_q) - RES_EW'(EXP_OFF) + RES_EW'(mant_r[SIG_W]);
        unused_hidden = mant_r[SIG_W-1];
        if (zero_q)
            fin_d = {1'b1, {(WORD_W-1){1'b0}}};
        else if (!exp_s[RES_EW-1] && exp_s >= RES_EW'(EXP_MAX))
            fin_d = neg_q ? {1'b1, {EXP_W{1'b1}}, {(SIG_W-1){1'b0}}}
                          : {1'b0, {(EXP_W-1){1'b1}}, 1'b0, {(SIG_W-1){1'b1}}};
        else if (exp_s[RES_EW-1] || exp_s == '0)
            fin_d = {neg_q, {(WORD_W-1){1'b0}}};
        else
            fin_d = {neg_q, exp_s[EXP_W-1:0],
                     mant_r[SIG_W] ? {(SIG_W-1){1'b0}} : mant_r[SIG_W-2:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q   <= '0;
            spec5_q <= '0;
        end else begin
            fin_q   <= fin_d;
            spec5_q <= spec4_q;
        end
    end

    // OUT stage
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (spec5_q.nan)
            res <= {1'b0, {EXP_W{1'b1}}, 1'b1, {(SIG_W-2){1'b0}}};
        else if (spec5_q.inf)
            res <= {spec5_q.sign, {EXP_W{1'b1}}, {(SIG_W-1){1'b0}}};
        else
            res <= fin_q;
    end

    assert_neg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |=> (fin_q == {1'b1, {(WORD_W-1){1'b0}}}));

    assert_no_pos_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec5_q.nan && !spec5_q.inf) |=> (res != {1'b0, {EXP_W{1'b1}}, {(SIG_W-1){1'b0}}}));
endmodule

// File: rtl/fpdual_fma.sv
module fpdual_fma
    import fpdual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_x,
    input  logic [WORD_W-1:0] in_y,
    input  logic [WORD_W-1:0] in_z,
    input  logic [WORD_W-1:0] in_w,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_sum,
    output logic [WORD_W-1:0] out_diff
);
    prod_t p1, p2;

    fpdual_mul u_mul_xy (.clk(clk), .rst_n(rst_n), .opa(in_x), .opb(in_y), .prod(p1));
    fpdual_mul u_mul_zw (.clk(clk), .rst_n(rst_n), .opa(in_z), .opb(in_w), .prod(p2));

    function automatic logic [FIELD_W-1:0] jam_shift(input logic [FIELD_W-1:0] v,
                                                     input logic [EXPS_W-1:0] d);
        logic [FIELD_W-1:0] r;
        logic               lost;
        if (d >= EXPS_W'(FIELD_W)) begin
            r    = '0;
            lost = |v;
        end else begin
            r    = v >> d;
            lost = |(v & ~({FIELD_W{1'b1}} << d));
        end
        return {r[FIELD_W-1:1], r[0] | lost};
    endfunction

    // ALIGN stage
    logic                     big1;
    logic [EXPS_W-1:0]        dd, emax_d;
    logic [FIELD_W-1:0]       a1, a2;
    logic signed [ACC_W-1:0]  v1_d, v2_d, v1_q, v2_q;
    logic [EXPS_W-1:0]        emax2_q, emax3_q;
    spec_t                    ss_d, sd_d, ss2_q, sd2_q, ss3_q, sd3_q;
    logic                     nan_any;

    always_comb begin
        big1   = (p1.exp >= p2.exp);
        dd     = big1 ? p1.exp - p2.exp : p2.exp - p1.exp;
        emax_d = big1 ? p1.exp : p2.exp;
        a1     = big1 ? {p1.sig, {GUARD{1'b0}}} : jam_shift({p1.sig, {GUARD{1'b0}}}, dd);
        a2     = big1 ? jam_shift({p2.sig, {GUARD{1'b0}}}, dd) : {p2.sig, {GUARD{1'b0}}};
        v1_d   = p1.sign ? -$signed({2'b00, a1}) : $signed({2'b00, a1});
        v2_d   = p2.sign ? -$signed({2'b00, a2}) : $signed({2'b00, a2});
        nan_any   = p1.nan | p2.nan;
        ss_d.nan  = nan_any | (p1.inf & p2.inf & (p1.sign != p2.sign));
        sd_d.nan  = nan_any | (p1.inf & p2.inf & (p1.sign == p2.sign));
        ss_d.inf  = ~ss_d.nan & (p1.inf | p2.inf);
        sd_d.inf  = ~sd_d.nan & (p1.inf | p2.inf);
        ss_d.sign = p1.inf ? p1.sign : p2.sign;
        sd_d.sign = p1.inf ? p1.sign : ~p2.sign;
    end

    // ALIGN and ADDSUB registers
    logic signed [ACC_W-1:0] sum_q, diff_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= '0;  v2_q <= '0;  emax2_q <= '0;  ss2_q <= '0;  sd2_q <= '0;
            sum_q <= '0; diff_q <= '0; emax3_q <= '0; ss3_q <= '0;  sd3_q <= '0;
        end else begin
            v1_q    <= v1_d;
            v2_q    <= v2_d;
            emax2_q <= emax_d;
            ss2_q   <= ss_d;
            sd2_q   <= sd_d;
            sum_q   <= v1_q + v2_q;
            diff_q  <= v1_q - v2_q;
            emax3_q <= emax2_q;
            ss3_q   <= ss2_q;
            sd3_q   <= sd2_q;
        end
    end

    fpdual_round u_rnd_sum  (.clk(clk), .rst_n(rst_n), .acc(sum_q),  .emax(emax3_q), .spec(ss3_q), .res(out_sum));
    fpdual_round u_rnd_diff (.clk(clk), .rst_n(rst_n), .acc(diff_q), .emax(emax3_q), .spec(sd3_q), .res(out_diff));

    // valid travels with the data
    logic [N_STAGES-1:0] vld;
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= {vld[N_STAGES-2:0], in_valid};
    end
    assign out_valid = vld[N_STAGES-1];

    // cycles since reset, saturating, to guard the latency window
    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rst <= '0;
        else if (since_rst < 4'(N_STAGES))   since_rst <= since_rst + 4'd1;
    end

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(N_STAGES)) |-> (out_valid == $past(in_valid, 6)));

    assert_zero_z_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(N_STAGES) && out_valid &&
         $past(in_valid && in_z[WORD_W-2 -: EXP_W] == '0, 6)) |-> (out_sum == out_diff));
endmodule

// File: tb/fpdual_fma_bench.sv
module fpdual_fma_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_x = '0, in_y = '0, in_z = '0, in_w = '0;
    logic        out_valid;
    logic [31:0] out_sum, out_diff;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpdual_fma u_fpdual_fma (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_w(in_w),
        .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
    );

    // {x, y, z, w, expected sum, expected difference}
    localparam logic [191:0] VEC [NV] = '{
        {32'h40000000, 32'h40400000, 32'h40800000, 32'h3F000000, 32'h41000000, 32'h40800000}, // R1 R2 6+2, 6-2
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h40000000, 32'h80000000}, // R4 1-1 -> -0
        {32'hBF800000, 32'h40400000, 32'h40000000, 32'h40000000, 32'h3F800000, 32'hC0E00000}, // R2 -3+4, -3-4
        {32'h3F800001, 32'h3F800001, 32'h00000000, 32'h3F800000, 32'h3F800002, 32'h3F800002}, // R1 R10 floor positive
        {32'h3F800001, 32'hBF800001, 32'h00000000, 32'h3F800000, 32'hBF800003, 32'hBF800003}, // R1 floor negative
        {32'h3F800001, 32'hBF800001, 32'h3F800000, 32'h3F800000, 32'hB4800001, 32'hC0000002}, // R1 R2 fused cancellation
        {32'h7F000000, 32'h40000000, 32'h00000000, 32'h00000000, 32'h7F7FFFFF, 32'h7F7FFFFF}, // R8 positive overflow
        {32'h7F000000, 32'hC0000000, 32'h00000000, 32'h00000000, 32'hFF800000, 32'hFF800000}, // R8 negative overflow
        {32'h7FC00000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 32'h7FC00000}, // R5 NaN input
        {32'h7F800000, 32'h00000000, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 32'h7FC00000}, // R5 inf times zero
        {32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h7FC00000}, // R6 inf-inf only in diff
        {32'h3F800000, 32'h3F800000, 32'hFF800000, 32'h3F800000, 32'hFF800000, 32'h7F800000}, // R6 single infinity
        {32'h00000001, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'hBF800000}, // R7 subnormal as zero
        {32'h00800000, 32'h3F000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}, // R9 positive flush
        {32'h00800000, 32'hBF000000, 32'h00000000, 32'h00000000, 32'h80000000, 32'h80000000}, // R9 negative flush
        {32'h40000000, 32'h40400000, 32'hC0000000, 32'h40400000, 32'h80000000, 32'h41400000}, // R4 6-6 -> -0
        {32'h4B800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h4B800000, 32'h4B7FFFFF}, // R1 R2 2^24 +/- 1
        {32'h3F800000, 32'h3F800000, 32'h4B800000, 32'h3F800000, 32'h4B800000, 32'hCB7FFFFF}, // R2 1 - 2^24
        {32'h3F800000, 32'h3F800000, 32'hB3000000, 32'h3F800000, 32'h3F7FFFFF, 32'h3F800000}  // R1 sticky 1 -/+ 2^-25
    };
    localparam int TAG [NV] = '{1, 4, 2, 1, 1, 1, 8, 8, 5, 5, 6, 6, 7, 9, 9, 4, 1, 2, 1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic drive(input logic v, input logic [31:0] x, y, z, w);
        in_valid = v; in_x = x; in_y = y; in_z = z; in_w = w;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", {31'b0, out_valid}, 32'd0, "out_valid in reset");
        check("R11", out_sum, 32'd0, "out_sum in reset");
        check("R11", out_diff, 32'd0, "out_diff in reset");
        rst_n = 1'b1;

        // table walk, back to back: one set per cycle (R3)
        for (int j = 0; j < NV + 6; j++) begin
            @(negedge clk);
            if (j >= 6) begin
                check($sformatf("R3 vec%0d", j - 6), {31'b0, out_valid}, 32'd1, "out_valid");
                check($sformatf("R%0d vec%0d", TAG[j-6], j - 6), out_sum,  VEC[j-6][63:32], "sum");
                check($sformatf("R%0d vec%0d", TAG[j-6], j - 6), out_diff, VEC[j-6][31:0],  "diff");
            end else begin
                check("R3", {31'b0, out_valid}, 32'd0, "out_valid before first result");
            end
            if (j < NV)
                drive(1'b1, VEC[j][191:160], VEC[j][159:128], VEC[j][127:96], VEC[j][95:64]);
            else
                drive(1'b0, '0, '0, '0, '0);
        end

        // R3: single pulse latency window
        @(negedge clk);
        drive(1'b1, 32'h40A00000, 32'h40000000, 32'h3FC00000, 32'h40000000); // 10+3, 10-3
        @(negedge clk);
        drive(1'b0, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000);
        repeat (4) @(negedge clk);
        check("R3", {31'b0, out_valid}, 32'd0, "out_valid at 5 cycles");
        @(negedge clk);
        check("R3", {31'b0, out_valid}, 32'd1, "out_valid at 6 cycles");
        check("R1", out_sum, 32'h41500000, "sum 13");
        check("R2", out_diff, 32'h40E00000, "diff 7");
        @(negedge clk);
        check("R3", {31'b0, out_valid}, 32'd0, "out_valid at 7 cycles");

        // R10 and R7: negative subnormal z gives equal outputs
        drive(1'b1, 32'h40400000, 32'hC0A00000, 32'h807FFFFF, 32'h41200000);
        @(negedge clk);
        drive(1'b0, '0, '0, '0, '0);
        repeat (5) @(negedge clk);
        check("R10", out_sum, 32'hC1700000, "sum -15");
        check("R10", out_diff, out_sum, "diff equals sum");

        // R11: reset mid-stream clears outputs
        drive(1'b1, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        drive(1'b0, '0, '0, '0, '0);
        check("R11", {31'b0, out_valid}, 32'd0, "out_valid after reset");
        check("R11", out_sum, 32'd0, "out_sum after reset");
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R3", {31'b0, out_valid}, 32'd0, "no result from reset cycles");

        finish_run();
    end
endmodule